// File: doc/BRIEF.md
# Serial Receive Queue with Flow-Control Hysteresis

This block turns an asynchronous 8N1 serial input into bytes and holds them in a small circular queue. A processor polls the queue. It reads one byte per strobe from a data output that always shows the oldest byte, and a data-available flag tells it when a byte is waiting. The line is sampled by a 16x oversampling tick. That tick comes from dividing the system clock by an integer, so a clock that is a multiple of 1.8432 MHz gives a standard bit rate. The default divide of 10 suits an 18.432 MHz clock at 115200 baud.

The block drives an active-low request-to-send output from the queue occupancy, with two thresholds and hysteresis. The output is withdrawn when the queue becomes nearly full, at about 80 percent. It is granted again only after the queue has drained to about 60 percent. This leaves slack for a remote sender that is slow to react. A character that arrives while the queue is full is dropped and sets a sticky overrun flag. A character with a bad stop bit is dropped and sets a sticky framing flag.

Top module: `uart_rx_queue`

## Requirements
- R1: After reset, fillLevel is 0, dataAvail is 0, rtsN is 0 (asserted), and overrunErr and frameErr are 0.
- R2: A character is a low start bit, then 8 data bits least significant first, then a high stop bit. Each bit lasts 16*TICK_DIV clocks. A well-formed character is appended to the queue.
- R3: A low pulse on rxd shorter than half a bit is not taken as a start bit. It adds nothing to the queue and sets no flag.
- R4: A character whose stop bit is sampled low is not stored, and frameErr becomes 1 and stays 1 until reset.
- R5: rdData shows the oldest stored byte. A read strobe while dataAvail is 1 removes that byte. Bytes come out in arrival order, fillLevel equals the number held, and dataAvail is 1 exactly when fillLevel is nonzero. A read strobe on an empty queue changes nothing.
- R6: A character that completes while the queue holds DEPTH (16) bytes, with no read in the same cycle, is dropped. The stored bytes are unchanged, and overrunErr becomes 1 and stays 1 until reset.
- R7: rtsN goes to 1 (deasserted) in the cycle the fill level reaches RTS_DROP (13) or more.
- R8: Once deasserted, rtsN stays 1 while the level drains through values above RTS_RAISE, and returns to 0 when the level reaches RTS_RAISE (10) or less.
- R9: While the level lies strictly between RTS_RAISE and RTS_DROP, rtsN keeps its previous value. Rising from empty through 11 and 12 leaves it at 0.
- R10: When a character completes in the same cycle as a read strobe on a full queue, the read byte is removed and the new byte is stored. fillLevel stays at DEPTH and overrunErr stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxd | input | 1 | Serial receive line, idle high, asynchronous |
| rdStrobe | input | 1 | Removes the oldest byte when dataAvail is 1 |
| rdData | output | 8 | Oldest byte in the queue |
| dataAvail | output | 1 | Queue holds at least one byte |
| fillLevel | output | $clog2(DEPTH+1) | Number of bytes held |
| rtsN | output | 1 | Request-to-send, active low, hysteresis-controlled |
| overrunErr | output | 1 | Sticky: a character was dropped on a full queue |
| frameErr | output | 1 | Sticky: a character had a low stop bit |

## Verification
Two events can fall in the same clock edge: a completed character being appended and a read strobe removing the head. When the queue is full, this decides whether the character survives. The bench measures the fixed delay from the launch of a start bit to the growth of fillLevel, and it launches every character at the same phase of the divider. It then fills the queue and places a single read strobe exactly on the append edge of the seventeenth character. It judges the result by three things: fillLevel staying at 16, overrunErr staying 0, and the new byte coming out last when the queue is drained.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rxState_t;

  // Strobes from the receive control to the queue datapath
  typedef struct packed {
    logic shiftEn;   // a data bit was sampled
    logic rxBit;     // value of that bit
    logic endGood;   // character complete, stop bit high
    logic endBad;    // character complete, stop bit low
  } rxStrobe_t;

endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import uart_rxq_pkg::*;
#(
  parameter int TICK_DIV  = 10,
  parameter int OVS       = 16,
  parameter int DATA_BITS = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      rxd,
  output rxStrobe_t strb
);

  localparam int DIV_W = $clog2(TICK_DIV + 1);
  localparam int CNT_W = $clog2(OVS);
  localparam int BIT_W = $clog2(DATA_BITS);
  // detection already costs about one tick of the synchronizer and divider
  localparam int START_WAIT = OVS / 2 - 2;

  logic [1:0]       syncQ;
  logic [DIV_W-1:0] divCnt;
  logic             tick;
  logic             rxS;
  rxState_t         st, stNext;
  logic [CNT_W-1:0] smpCnt, smpNext;
  logic [BIT_W-1:0] bitCnt, bitNext;

  assign tick = (divCnt == DIV_W'(TICK_DIV - 1));
  assign rxS  = syncQ[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ  <= 2'b11;
      divCnt <= '0;
      st     <= ST_IDLE;
      smpCnt <= '0;
      bitCnt <= '0;
    end else begin
      syncQ  <= {syncQ[0], rxd};
      divCnt <= tick ? '0 : divCnt + 1'b1;
      st     <= stNext;
      smpCnt <= smpNext;
      bitCnt <= bitNext;
    end
  end

  always_comb begin
    stNext  = st;
    smpNext = smpCnt;
    bitNext = bitCnt;
    strb    = '0;
    if (tick) begin
      case (st)
        ST_IDLE: begin
          if (!rxS) begin
            stNext  = ST_START;
            smpNext = '0;
          end
        end
        ST_START: begin
          if (smpCnt == CNT_W'(START_WAIT)) begin
            smpNext = '0;
            bitNext = '0;
            stNext  = rxS ? ST_IDLE : ST_DATA;
          end else begin
            smpNext = smpCnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (smpCnt == CNT_W'(OVS - 1)) begin
            smpNext      = '0;
            strb.shiftEn = 1'b1;
            strb.rxBit   = rxS;
            if (bitCnt == BIT_W'(DATA_BITS - 1)) stNext = ST_STOP;
            else bitNext = bitCnt + 1'b1;
          end else begin
            smpNext = smpCnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (smpCnt == CNT_W'(OVS - 1)) begin
            smpNext      = '0;
            strb.endGood = rxS;
            strb.endBad  = !rxS;
            stNext       = ST_IDLE;
          end else begin
            smpNext = smpCnt + 1'b1;
          end
        end
        default: stNext = ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rxq_data.sv
module rxq_data
  import uart_rxq_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int DEPTH     = 16,
  parameter int RTS_DROP  = 13,
  parameter int RTS_RAISE = 10
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  rxStrobe_t                    strb,
  input  logic                         rdStrobe,
  output logic [DATA_BITS-1:0]         rdData,
  output logic                         dataAvail,
  output logic [$clog2(DEPTH+1)-1:0]   fillLevel,
  output logic                         rtsN,
  output logic                         overrunErr,
  output logic                         frameErr
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic [DATA_BITS-1:0] mem [DEPTH];
  logic [DATA_BITS-1:0] shReg;
  logic [PTR_W-1:0]     wrPtr, rdPtr;
  logic [LVL_W-1:0]     count, countNext;
  logic                 doPop, doPush, isFull;

  function automatic logic [PTR_W-1:0] ptrInc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign isFull = (count == LVL_W'(DEPTH));
  assign doPop  = rdStrobe && (count != '0);
  // a read on the same edge frees the slot the new byte needs
  assign doPush = strb.endGood && (!isFull || doPop);

  always_comb begin
    case ({doPush, doPop})
      2'b10:   countNext = count + 1'b1;
      2'b01:   countNext = count - 1'b1;
      default: countNext = count;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg      <= '0;
      wrPtr      <= '0;
      rdPtr      <= '0;
      count      <= '0;
      rtsN       <= 1'b0;
      overrunErr <= 1'b0;
      frameErr   <= 1'b0;
    end else begin
      if (strb.shiftEn) shReg <= {strb.rxBit, shReg[DATA_BITS-1:1]};
      if (doPush) wrPtr <= ptrInc(wrPtr);
      if (doPop)  rdPtr <= ptrInc(rdPtr);
      count <= countNext;
      if (countNext >= LVL_W'(RTS_DROP))       rtsN <= 1'b1;
      else if (countNext <= LVL_W'(RTS_RAISE)) rtsN <= 1'b0;
      if (strb.endGood && isFull && !doPop) overrunErr <= 1'b1;
      if (strb.endBad) frameErr <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= shReg;
  end

  assign rdData    = mem[rdPtr];
  assign dataAvail = (count != '0);
  assign fillLevel = count;

endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
  import uart_rxq_pkg::*;
#(
  parameter int TICK_DIV  = 10,
  parameter int DEPTH     = 16,
  parameter int RTS_DROP  = 13,
  parameter int RTS_RAISE = 10
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       rxd,
  input  logic                       rdStrobe,
  output logic [7:0]                 rdData,
  output logic                       dataAvail,
  output logic [$clog2(DEPTH+1)-1:0] fillLevel,
  output logic                       rtsN,
  output logic                       overrunErr,
  output logic                       frameErr
);

  localparam int OVS       = 16;
  localparam int DATA_BITS = 8;

  rxStrobe_t strb;

  rxq_ctrl #(
    .TICK_DIV (TICK_DIV),
    .OVS      (OVS),
    .DATA_BITS(DATA_BITS)
  ) u_ctrl (
    .clk (clk),
    .rstN(rstN),
    .rxd (rxd),
    .strb(strb)
  );

  rxq_data #(
    .DATA_BITS(DATA_BITS),
    .DEPTH    (DEPTH),
    .RTS_DROP (RTS_DROP),
    .RTS_RAISE(RTS_RAISE)
  ) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .rdStrobe  (rdStrobe),
    .rdData    (rdData),
    .dataAvail (dataAvail),
    .fillLevel (fillLevel),
    .rtsN      (rtsN),
    .overrunErr(overrunErr),
    .frameErr  (frameErr)
  );

endmodule

// File: rtl/uart_rx_queue_chk.sv
module uart_rx_queue_chk #(
  parameter int DEPTH     = 16,
  parameter int RTS_DROP  = 13,
  parameter int RTS_RAISE = 10
) (
  input logic                       clk,
  input logic                       rstN,
  input logic [$clog2(DEPTH+1)-1:0] fillLevel,
  input logic                       dataAvail,
  input logic                       rtsN,
  input logic                       overrunErr,
  input logic                       frameErr
);

  localparam int LVL_W = $clog2(DEPTH + 1);

  assert_level_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    fillLevel <= LVL_W'(DEPTH));

  assert_avail_match_R5: assert property (@(posedge clk) disable iff (!rstN)
    dataAvail == (fillLevel != '0));

  assert_level_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (fillLevel == $past(fillLevel)) || (fillLevel == $past(fillLevel) + 1'b1) ||
    (fillLevel + 1'b1 == $past(fillLevel)));

  assert_rts_drop_R7: assert property (@(posedge clk) disable iff (!rstN)
    fillLevel >= LVL_W'(RTS_DROP) |-> rtsN);

  assert_rts_raise_R8: assert property (@(posedge clk) disable iff (!rstN)
    fillLevel <= LVL_W'(RTS_RAISE) |-> !rtsN);

  assert_rts_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (fillLevel > LVL_W'(RTS_RAISE) && fillLevel < LVL_W'(RTS_DROP)) |-> $stable(rtsN));

  assert_overrun_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    overrunErr |=> overrunErr);

  assert_overrun_full_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrunErr) |-> $past(fillLevel) == LVL_W'(DEPTH));

  assert_frame_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |=> frameErr);

endmodule

bind uart_rx_queue uart_rx_queue_chk #(
  .DEPTH    (DEPTH),
  .RTS_DROP (RTS_DROP),
  .RTS_RAISE(RTS_RAISE)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .fillLevel (fillLevel),
  .dataAvail (dataAvail),
  .rtsN      (rtsN),
  .overrunErr(overrunErr),
  .frameErr  (frameErr)
);

// File: tb/uart_rx_queue_tb.sv
`timescale 1ns/1ps
module uart_rx_queue_tb;

  localparam int TICK_DIV = 2;
  localparam int DEPTH    = 16;
  localparam int BIT_T    = 16 * TICK_DIV;
  localparam int LVL_W    = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             rxd = 1'b1;
  logic             rdStrobe = 1'b0;
  logic [7:0]       rdData;
  logic             dataAvail;
  logic [LVL_W-1:0] fillLevel;
  logic             rtsN;
  logic             overrunErr;
  logic             frameErr;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int lastLaunch = 0;
  int latD = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_rx_queue #(
    .TICK_DIV (TICK_DIV),
    .DEPTH    (DEPTH),
    .RTS_DROP (13),
    .RTS_RAISE(10)
  ) u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .rxd       (rxd),
    .rdStrobe  (rdStrobe),
    .rdData    (rdData),
    .dataAvail (dataAvail),
    .fillLevel (fillLevel),
    .rtsN      (rtsN),
    .overrunErr(overrunErr),
    .frameErr  (frameErr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // one character; every launch sits on the same divider phase
  task automatic sendFrame(input logic [7:0] b, input bit goodStop);
    @(negedge clk);
    while (cyc % TICK_DIV != 0) @(negedge clk);
    lastLaunch = cyc;
    rxd = 1'b0;
    repeat (BIT_T) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (BIT_T) @(negedge clk);
    end
    if (goodStop) begin
      rxd = 1'b1;
      repeat (BIT_T) @(negedge clk);
    end else begin
      rxd = 1'b0;
      repeat (12 * TICK_DIV) @(negedge clk);
      rxd = 1'b1;
      repeat (4 * TICK_DIV) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic readByte(input logic [7:0] exp, input string req);
    @(negedge clk);
    chk(req, rdData, exp);
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R1 fillLevel", fillLevel, 0);
    chk("R1 dataAvail", dataAvail, 0);
    chk("R1 rtsN", rtsN, 0);
    chk("R1 overrunErr", overrunErr, 0);
    chk("R1 frameErr", frameErr, 0);
  endtask

  task automatic testBasic();
    sendFrame(8'hA5, 1'b1);
    sendFrame(8'h3C, 1'b1);
    chk("R5 level after two", fillLevel, 2);
    chk("R5 dataAvail", dataAvail, 1);
    readByte(8'hA5, "R2 first byte");
    readByte(8'h3C, "R2 second byte");
    chk("R5 level drained", fillLevel, 0);
    chk("R5 dataAvail drained", dataAvail, 0);
    // read strobe on empty queue
    @(negedge clk);
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
    @(negedge clk);
    chk("R5 empty read level", fillLevel, 0);
    sendFrame(8'h01, 1'b1);
    readByte(8'h01, "R5 after empty read");
  endtask

  task automatic testGlitch();
    @(negedge clk);
    rxd = 1'b0;
    repeat (4 * TICK_DIV) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * 10 * BIT_T) @(negedge clk);
    chk("R3 glitch level", fillLevel, 0);
    chk("R3 glitch frameErr", frameErr, 0);
  endtask

  task automatic testFraming();
    sendFrame(8'h77, 1'b0);
    repeat (2 * BIT_T) @(negedge clk);
    chk("R4 bad stop not stored", fillLevel, 0);
    chk("R4 frameErr set", frameErr, 1);
    sendFrame(8'h9E, 1'b1);
    chk("R4 frameErr sticky", frameErr, 1);
    readByte(8'h9E, "R4 next byte intact");
  endtask

  task automatic testFillAndRts();
    // first byte: measure launch-to-append latency
    fork
      sendFrame(8'h41, 1'b1);
      begin
        while (fillLevel == 0) @(negedge clk);
        latD = cyc - lastLaunch;
      end
    join
    for (int i = 2; i <= 16; i++) begin
      sendFrame(8'h40 + 8'(i), 1'b1);
      chk("R5 fill level", fillLevel, i);
      if (i >= 13)      chk("R7 rts drop", rtsN, 1);
      else if (i >= 11) chk("R9 rts hold low", rtsN, 0);
      else              chk("R7 rts below drop", rtsN, 0);
    end
    // coincident append and read on a full queue
    fork
      sendFrame(8'h51, 1'b1);
      begin
        @(negedge clk);
        while (cyc != lastLaunch + latD - 1) @(negedge clk);
        chk("R10 head at coincidence", rdData, 8'h41);
        rdStrobe = 1'b1;
        @(negedge clk);
        rdStrobe = 1'b0;
      end
    join
    chk("R10 level stays full", fillLevel, 16);
    chk("R10 no overrun", overrunErr, 0);
    sendFrame(8'h52, 1'b1);
    chk("R6 overrun set", overrunErr, 1);
    chk("R6 level full", fillLevel, 16);
    for (int k = 1; k <= 16; k++) begin
      readByte(8'h41 + 8'(k), "R6 R10 drain order");
      chk("R8 rts while draining", rtsN, (16 - k) > 10 ? 1 : 0);
    end
    chk("R6 dropped byte absent", dataAvail, 0);
    chk("R6 overrun sticky", overrunErr, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testBasic();
    testGlitch();
    testFraming();
    testFillAndRts();
    finishRun();
  end

endmodule